// File: doc/BRIEF.md
# DRAM Command Decoder and Bank Tracker

This block sits at the command side of a four-bank graphics DRAM device model. On every rising clock edge it samples the chip-select input, the three active-low command lines, two bank-select bits and a 12-bit address bus. From these it works out which command is being issued: Activate, Read, Write, Precharge, Refresh or Mode Register Set. It checks the command against the open or closed state of each bank and then updates that state. For every accepted command it reports the decoded kind, the bank, a row or opcode value and a column address on a registered strobe. Commands that break the bank rules raise an illegal flag and have no effect.

The block keeps one open flag and one stored row for each bank. It builds the Read/Write column address from the column bits of the bus. The one address bit that does not belong to the column is read as an auto-precharge request. It also watches the clock-enable input and sorts each low period into one of three power states: precharge power-down, active power-down or self refresh. Self refresh ends on the rising edge of clock enable itself, without waiting for a clock. Every registered output changes on the same rising clock edge that samples the inputs behind it.

Top module: `dram_cmd_front`

## Requirements
- R1: While reset is low, and after it is released, all banks are closed, cmdValid and illegal are 0 and pwrState is 0 (normal).
- R2: An edge that samples csN high changes nothing: cmdValid and illegal stay 0 and bankOpen keeps its value, whatever the other inputs hold.
- R3: With csN low and cke high, the lines {rasN,casN,weN} are decoded as 011 Activate (cmdKind 1), 101 Read (2), 100 Write (3), 010 Precharge (4), 001 Refresh (5), 000 Mode Register Set (6). The value 111 is a no-operation (cmdKind 0, cmdValid 0).
- R4: An Activate to a closed bank opens it and stores addr[11:0] as its row, with cmdRow = addr and cmdBank = ba. An Activate to an open bank raises illegal and changes no state.
- R5: A Read or Write to an open bank gives cmdCol = {addr[9], addr[7:0]}, gives cmdRow equal to the row stored for that bank, and sets cmdAutoPre = addr[8]. A Read or Write to a closed bank raises illegal and changes no state.
- R6: A Read or Write accepted with addr[8] = 1 closes its bank on the next clock edge. bankOpen still shows the bank open right after the command edge.
- R7: A Precharge with addr[8] = 0 closes only bank ba. With addr[8] = 1 it closes every bank.
- R8: A Refresh while any bank is open raises illegal. A Mode Register Set is always accepted and reports its opcode addr[11:0] on cmdRow.
- R9: When cke is sampled low in the normal state, pwrState becomes 1 (precharge power-down) if no bank is open and 2 (active power-down) otherwise. A later edge that samples cke high returns it to 0. No command is executed while powered down or on the exit edge, and no bank state changes.
- R10: A Refresh sampled with cke low while all banks are idle makes pwrState 3 (self refresh). A rising edge on cke ends self refresh at once, with no clock edge needed.
- R11: A Read or Write sampled with cke low in the normal state raises illegal and is not executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe command line, active low |
| casN | input | 1 | Column strobe command line, active low |
| weN | input | 1 | Write-enable command line, active low |
| ba | input | 2 | Bank select |
| addr | input | 12 | Row, column, auto-precharge and opcode bus |
| cmdValid | output | 1 | Pulse for an accepted command |
| cmdKind | output | 3 | Decoded kind, coded as in R3 |
| cmdBank | output | 2 | Bank of the command |
| cmdRow | output | 12 | Activate row, stored row for Read/Write, or Mode Register opcode |
| cmdCol | output | 9 | Column address for Read/Write |
| cmdAutoPre | output | 1 | Read/Write carries auto-precharge |
| illegal | output | 1 | Pulse for a rejected command |
| pwrState | output | 2 | 0 normal, 1 precharge power-down, 2 active power-down, 3 self refresh |
| bankOpen | output | 4 | Open flag per bank |

## Verification
The in-line assertions check the invariants that must hold on every cycle. An accepted command never also raises illegal. An Activate leaves its bank open. Auto-precharge closes the bank on the following edge. Neither self refresh nor precharge power-down can coexist with an open bank. What the assertions cannot show is the decode table itself, the exact column bit selection, single-bank versus all-bank precharge, commands ignored during power-down and on the exit edge, and the clockless self-refresh exit. The bench's scenarios cover these, sweeping the command codes, banks and address patterns and computing the expected values from the requirements.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmdKind_e;

  typedef enum logic [1:0] {
    PWR_ON   = 2'd0,
    PWR_PPD  = 2'd1,
    PWR_APD  = 2'd2,
    PWR_SREF = 2'd3
  } pwrState_e;

  // strobes from the control to the bank datapath
  typedef struct packed {
    logic     accept;
    logic     illegal;
    cmdKind_e kind;
    logic     openSel;
    logic     closeSel;
    logic     closeAll;
    logic     apArm;
  } ctrlStrobe_t;

endpackage

// File: rtl/dcf_ctrl.sv
module dcf_ctrl
  import dcf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cke,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic        apBit,
  input  logic        selOpen,
  input  logic        anyOpen,
  output ctrlStrobe_t strobe,
  output logic [1:0]  pwrState
);

  cmdKind_e  decKind;
  pwrState_e pwrQ, pwrNext;
  logic      srefQ, srefSet;

  // command table, valid only with chip select low
  always_comb begin
    decKind = CMD_NOP;
    if (!csN) begin
      unique case ({rasN, casN, weN})
        3'b011:  decKind = CMD_ACT;
        3'b101:  decKind = CMD_RD;
        3'b100:  decKind = CMD_WR;
        3'b010:  decKind = CMD_PRE;
        3'b001:  decKind = CMD_REF;
        3'b000:  decKind = CMD_MRS;
        default: decKind = CMD_NOP;
      endcase
    end
  end

  always_comb begin
    strobe  = '0;
    strobe.kind = CMD_NOP;
    pwrNext = pwrQ;
    srefSet = 1'b0;
    if (!srefQ) begin
      if (pwrQ != PWR_ON) begin
        if (cke) pwrNext = PWR_ON;
      end else if (!cke) begin
        strobe.kind = decKind;
        if (decKind == CMD_REF && !anyOpen) srefSet = 1'b1;
        else pwrNext = anyOpen ? PWR_APD : PWR_PPD;
        if (decKind == CMD_RD || decKind == CMD_WR ||
            (decKind == CMD_REF && anyOpen))
          strobe.illegal = 1'b1;
      end else begin
        strobe.kind = decKind;
        unique case (decKind)
          CMD_ACT: begin
            if (selOpen) strobe.illegal = 1'b1;
            else begin
              strobe.accept  = 1'b1;
              strobe.openSel = 1'b1;
            end
          end
          CMD_RD, CMD_WR: begin
            if (!selOpen) strobe.illegal = 1'b1;
            else begin
              strobe.accept = 1'b1;
              strobe.apArm  = apBit;
            end
          end
          CMD_PRE: begin
            strobe.accept   = 1'b1;
            strobe.closeAll = apBit;
            strobe.closeSel = !apBit;
          end
          CMD_REF: begin
            if (anyOpen) strobe.illegal = 1'b1;
            else strobe.accept = 1'b1;
          end
          CMD_MRS: strobe.accept = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwrQ <= PWR_ON;
    else       pwrQ <= pwrNext;
  end

  // self refresh: entered on a clock edge, left as soon as cke rises
  always_ff @(posedge clk or posedge cke or negedge rstN) begin
    if (!rstN)        srefQ <= 1'b0;
    else if (cke)     srefQ <= 1'b0;
    else if (srefSet) srefQ <= 1'b1;
  end

  assign pwrState = srefQ ? PWR_SREF : pwrQ;

  // R10
  sref_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    srefQ |-> !anyOpen);

  // R9
  ppd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_PPD) |-> !anyOpen);

endmodule

// File: rtl/dcf_bank.sv
module dcf_bank
  import dcf_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [$clog2(BANKS)-1:0] ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic                 selOpen,
  output logic                 anyOpen,
  output logic [BANKS-1:0]     bankOpen,
  output logic                 cmdValid,
  output logic [2:0]           cmdKind,
  output logic [$clog2(BANKS)-1:0] cmdBank,
  output logic [ADDR_W-1:0]    cmdRow,
  output logic [COL_W-1:0]     cmdCol,
  output logic                 cmdAutoPre,
  output logic                 illegal
);

  localparam int BANK_W = $clog2(BANKS);
  localparam int HI_W   = COL_W - AP_BIT;

  logic [ADDR_W-1:0] rowQ [BANKS];
  logic              apPendQ;
  logic [BANK_W-1:0] apBankQ;
  logic [COL_W-1:0]  colNow;
  logic              isAccess;

  // the auto-precharge bit is skipped when forming the column
  assign colNow   = {addr[AP_BIT+HI_W:AP_BIT+1], addr[AP_BIT-1:0]};
  assign selOpen  = bankOpen[ba];
  assign anyOpen  = |bankOpen;
  assign isAccess = (strobe.kind == CMD_RD) || (strobe.kind == CMD_WR);

  for (genvar g = 0; g < BANKS; g++) begin : gBank
    logic hit, apHit;
    assign hit   = (ba == BANK_W'(g));
    assign apHit = apPendQ && (apBankQ == BANK_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bankOpen[g] <= 1'b0;
        rowQ[g]     <= '0;
      end else if (strobe.openSel && hit) begin
        bankOpen[g] <= 1'b1;
        rowQ[g]     <= addr;
      end else if (strobe.closeAll || (strobe.closeSel && hit) || apHit) begin
        bankOpen[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      apPendQ    <= 1'b0;
      apBankQ    <= '0;
      cmdValid   <= 1'b0;
      illegal    <= 1'b0;
      cmdKind    <= CMD_NOP;
      cmdBank    <= '0;
      cmdRow     <= '0;
      cmdCol     <= '0;
      cmdAutoPre <= 1'b0;
    end else begin
      apPendQ    <= strobe.accept && strobe.apArm;
      apBankQ    <= ba;
      cmdValid   <= strobe.accept;
      illegal    <= strobe.illegal;
      cmdKind    <= (strobe.accept || strobe.illegal) ? strobe.kind : CMD_NOP;
      cmdBank    <= ba;
      cmdRow     <= isAccess ? rowQ[ba] : addr;
      cmdCol     <= colNow;
      cmdAutoPre <= strobe.accept && strobe.apArm;
    end
  end

  // R3
  valid_xor_illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && illegal));

  // R4
  act_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdKind == CMD_ACT) |-> bankOpen[cmdBank]);

  // R6
  ap_close_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdAutoPre) |=> !bankOpen[$past(cmdBank)]);

endmodule

// File: rtl/dram_cmd_front.sv
module dram_cmd_front
  import dcf_pkg::*;
#(
  parameter int BANKS  = 4,
  parameter int ADDR_W = 12,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cke,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              cmdValid,
  output logic [2:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ADDR_W-1:0] cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              cmdAutoPre,
  output logic              illegal,
  output logic [1:0]        pwrState,
  output logic [BANKS-1:0]  bankOpen
);

  ctrlStrobe_t strobe;
  logic        selOpen, anyOpen;

  dcf_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cke      (cke),
    .csN      (csN),
    .rasN     (rasN),
    .casN     (casN),
    .weN      (weN),
    .apBit    (addr[AP_BIT]),
    .selOpen  (selOpen),
    .anyOpen  (anyOpen),
    .strobe   (strobe),
    .pwrState (pwrState)
  );

  dcf_bank #(
    .BANKS  (BANKS),
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W),
    .AP_BIT (AP_BIT)
  ) i_bank (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .ba         (ba),
    .addr       (addr),
    .selOpen    (selOpen),
    .anyOpen    (anyOpen),
    .bankOpen   (bankOpen),
    .cmdValid   (cmdValid),
    .cmdKind    (cmdKind),
    .cmdBank    (cmdBank),
    .cmdRow     (cmdRow),
    .cmdCol     (cmdCol),
    .cmdAutoPre (cmdAutoPre),
    .illegal    (illegal)
  );

endmodule

// File: tb/test_dram_cmd_front.sv
module test_dram_cmd_front;

  localparam logic [2:0] C_ACT = 3'b011, C_RD = 3'b101, C_WR = 3'b100,
                         C_PRE = 3'b010, C_REF = 3'b001, C_MRS = 3'b000,
                         C_NOP = 3'b111;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, cke, csN, rasN, casN, weN;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        cmdValid, cmdAutoPre, illegal;
  logic [2:0]  cmdKind;
  logic [1:0]  cmdBank, pwrState;
  logic [11:0] cmdRow;
  logic [8:0]  cmdCol;
  logic [3:0]  bankOpen;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [3:0] expOpen;

  dram_cmd_front i_dram_cmd_front (
    .clk(clk), .rstN(rstN), .cke(cke), .csN(csN), .rasN(rasN), .casN(casN),
    .weN(weN), .ba(ba), .addr(addr), .cmdValid(cmdValid), .cmdKind(cmdKind),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol),
    .cmdAutoPre(cmdAutoPre), .illegal(illegal), .pwrState(pwrState),
    .bankOpen(bankOpen)
  );

  function automatic logic [11:0] rowOf(input int b);
    return 12'(12'h0A3 + b * 12'h155);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at the falling edge, sample 1 ns after the next rising edge
  task automatic issue(input logic c, input logic [2:0] rcw, input logic [1:0] b,
                       input logic [11:0] a, input logic k);
    @(negedge clk);
    csN = c; {rasN, casN, weN} = rcw; ba = b; addr = a; cke = k;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finish_run();
  end

  initial begin
    rstN = 0; cke = 1; csN = 1; {rasN, casN, weN} = C_NOP; ba = 0; addr = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 open in reset", 32'(bankOpen), 0);
    chk("R1 pwr in reset", 32'(pwrState), 0);
    @(negedge clk); rstN = 1;
    issue(1, C_NOP, 0, 0, 1);
    chk("R1 valid", 32'(cmdValid), 0);
    chk("R1 illegal", 32'(illegal), 0);

    // R2: all command codes with chip select high
    for (int c = 0; c < 8; c++) begin
      issue(1, 3'(c), 2'(c), 12'(c * 12'h111), 1);
      chk("R2 valid", 32'(cmdValid), 0);
      chk("R2 illegal", 32'(illegal), 0);
      chk("R2 open", 32'(bankOpen), 0);
    end

    // R4 / R3: activate every bank
    expOpen = 0;
    for (int b = 0; b < 4; b++) begin
      issue(0, C_ACT, 2'(b), rowOf(b), 1);
      expOpen[b] = 1'b1;
      chk("R3 act kind", 32'(cmdKind), 1);
      chk("R4 act valid", 32'(cmdValid), 1);
      chk("R4 act row", 32'(cmdRow), 32'(rowOf(b)));
      chk("R4 act bank", 32'(cmdBank), 32'(b));
      chk("R4 open mask", 32'(bankOpen), 32'(expOpen));
    end
    issue(0, C_ACT, 2, 12'hFFF, 1);
    chk("R4 act open illegal", 32'(illegal), 1);
    chk("R4 act open valid", 32'(cmdValid), 0);
    issue(0, C_RD, 2, 12'h000, 1);
    chk("R4 row kept", 32'(cmdRow), 32'(rowOf(2)));

    // R5 / R3: column sweep over banks and patterns, auto-precharge off
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 6; k++) begin
        logic [11:0] a;
        logic [2:0]  rcw;
        a = 12'((b * 37 + k * 1001) & 12'hEFF);
        rcw = k[0] ? C_WR : C_RD;
        issue(0, rcw, 2'(b), a, 1);
        chk("R3 rw kind", 32'(cmdKind), k[0] ? 3 : 2);
        chk("R5 rw valid", 32'(cmdValid), 1);
        chk("R5 col", 32'(cmdCol), 32'({a[9], a[7:0]}));
        chk("R5 row", 32'(cmdRow), 32'(rowOf(b)));
        chk("R5 ap off", 32'(cmdAutoPre), 0);
      end
    end

    // R6: auto-precharge on bank 1
    issue(0, C_RD, 1, 12'h3FF, 1);
    chk("R6 ap flag", 32'(cmdAutoPre), 1);
    chk("R6 col", 32'(cmdCol), 32'(9'h1FF));
    chk("R6 still open", 32'(bankOpen), 32'hF);
    issue(0, C_NOP, 0, 0, 1);
    expOpen = 4'b1101;
    chk("R6 closed next", 32'(bankOpen), 32'(expOpen));
    issue(0, C_WR, 1, 12'h010, 1);
    chk("R5 closed illegal", 32'(illegal), 1);
    chk("R5 closed state", 32'(bankOpen), 32'(expOpen));

    // R8
    issue(0, C_REF, 0, 0, 1);
    chk("R8 ref open illegal", 32'(illegal), 1);
    issue(0, C_MRS, 3, 12'h5A3, 1);
    chk("R8 mrs valid", 32'(cmdValid), 1);
    chk("R3 mrs kind", 32'(cmdKind), 6);
    chk("R8 mrs opcode", 32'(cmdRow), 32'h5A3);

    // R9: active power-down, commands ignored, exit edge ignored
    issue(0, C_NOP, 0, 0, 0);
    chk("R9 apd", 32'(pwrState), 2);
    issue(0, C_ACT, 1, 12'h123, 0);
    chk("R9 down ignored", 32'(cmdValid), 0);
    chk("R9 down state", 32'(bankOpen), 32'(expOpen));
    issue(0, C_ACT, 1, 12'h123, 1);
    chk("R9 exit on", 32'(pwrState), 0);
    chk("R9 exit ignored", 32'(bankOpen), 32'(expOpen));

    // R11: read with cke low
    issue(0, C_RD, 0, 12'h001, 0);
    chk("R11 illegal", 32'(illegal), 1);
    chk("R11 not valid", 32'(cmdValid), 0);
    chk("R11 apd", 32'(pwrState), 2);
    issue(0, C_NOP, 0, 0, 1);
    chk("R11 back on", 32'(pwrState), 0);

    // R7
    issue(0, C_PRE, 0, 12'h000, 1);
    expOpen[0] = 1'b0;
    chk("R7 single", 32'(bankOpen), 32'(expOpen));
    issue(0, C_PRE, 0, 12'h100, 1);
    chk("R7 all", 32'(bankOpen), 0);
    chk("R3 pre kind", 32'(cmdKind), 4);

    // R9: precharge power-down
    issue(0, C_NOP, 0, 0, 0);
    chk("R9 ppd", 32'(pwrState), 1);
    issue(0, C_NOP, 0, 0, 1);
    chk("R9 ppd exit", 32'(pwrState), 0);
    issue(0, C_REF, 0, 0, 1);
    chk("R8 ref idle valid", 32'(cmdValid), 1);

    // R10: self refresh and clockless exit
    issue(0, C_REF, 0, 0, 0);
    chk("R10 sref", 32'(pwrState), 3);
    issue(1, C_NOP, 0, 0, 0);
    chk("R10 sref held", 32'(pwrState), 3);
    #1 cke = 1;
    #1 chk("R10 async exit", 32'(pwrState), 0);
    issue(0, C_ACT, 3, 12'h777, 1);
    chk("R10 cmd after exit", 32'(bankOpen), 32'h8);

    finish_run();
  end

endmodule